// File: doc/BRIEF.md
# Dual-Window On-Chip RAM Mapper

This block holds a 4 KiB on-chip RAM and makes it reachable through two address windows. One window serves instruction fetches and the other serves data accesses. Each window has its own base register and its own control register, both written over a device-control register port. The two windows always point at the same physical storage. A word written through one window can therefore be read back through the other at the same offset.

A system bus slave port compares each incoming address against the enabled windows. On a hit it serves a 32-bit word read or write from the shared RAM. On a miss it answers with an error. A window can only start on a 64 MiB boundary. Only the low 12 address bits select a location inside the RAM, so the 4 KiB image repeats throughout the window. When both windows are enabled at the same base, the RAM still appears there only once, and every access is answered exactly once.

Top module: `ocm_mapper`

## Requirements
- R1: After reset all four registers read zero, both windows are disabled, and every bus access gets an error response.
- R2: A write to the instruction base register (device-control address 0x018) or the data base register (0x01A) stores only bits 31:26 of the written value, so the stored value is the written value AND 0xFC000000. Reading the register returns the stored value.
- R3: A write to the instruction control register (0x019) or the data control register (0x01B) stores only bits 31:30, so the stored value is the written value AND 0xC0000000. Bit 31 enables the window. Bit 30 is kept and read back but has no other effect.
- R4: A bus access hits a window when that window's control bit 31 is set and address bits 31:26 equal bits 31:26 of that window's base register.
- R5: An access that hits no enabled window gets bus_err=1 and bus_ack=0. Its write data changes no RAM location.
- R6: The two windows alias one storage: a word written through one window reads back through the other window at the same offset.
- R7: The RAM location is chosen by address bits 11:2, which select one of 1024 words. Address bits 25:12 are ignored inside a window.
- R8: When both windows are enabled with the same base, an access at that base gets exactly one ack and no error, and it reads and writes the single shared RAM.
- R9: A new base or control value takes effect for bus accesses starting in the cycle right after the register write.
- R10: bus_ack or bus_err is raised exactly one cycle after an accepted bus_req, never both, and neither is raised without a request. Read data is valid together with bus_ack.
- R11: A read at any other device-control address returns zero. A write at any other device-control address changes none of the four registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dcr_wr | input | 1 | Register write strobe |
| dcr_rd | input | 1 | Register read strobe |
| dcr_addr | input | 10 | Register address |
| dcr_wdata | input | 32 | Register write data |
| dcr_rdata | output | 32 | Register read data (combinational, zero when dcr_rd is low) |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access claimed and completed |
| bus_err | output | 1 | Access hit no enabled window |

## Verification
The bench first drives directed patterns:
- Accesses in reset state show that nothing is claimed before a window is enabled.
- Garbage low bits in register writes expose the masking.
- Writes through one window followed by reads through the other show the two windows alias one RAM.
- Addresses with differing bits 25:12 show the offset wrap inside a window.
- An access in the cycle right after enabling separates same-cycle activation from a late one.
- The same-base case confirms a single response and coherent data.

After that, a seeded random mix of register rewrites over a few bases and random bus addresses is compared against a bench model of window hits and RAM contents. This separates hits from misses on either window and catches writes that leak on a miss.

// File: rtl/ocm_pkg.sv
package ocm_pkg;
  localparam logic [31:0] BASE_KEEP = 32'hFC00_0000;
  localparam logic [31:0] CTRL_KEEP = 32'hC000_0000;

  function automatic logic [31:0] keep_base(input logic [31:0] v);
    return v & BASE_KEEP;
  endfunction

  function automatic logic [31:0] keep_ctrl(input logic [31:0] v);
    return v & CTRL_KEEP;
  endfunction

  // window claims address when enabled and the 64 MiB region matches
  function automatic logic win_hit(input logic [31:0] base, input logic [31:0] ctrl,
                                   input logic [31:0] addr);
    return ctrl[31] && (addr[31:26] == base[31:26]);
  endfunction
endpackage

// File: rtl/ocm_regs.sv
module ocm_regs #(
  parameter int DCR_AW = 10,
  parameter logic [DCR_AW-1:0] REG_BASE_ADDR = 10'h018,
  parameter int NREGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dcr_wr,
  input  logic              dcr_rd,
  input  logic [DCR_AW-1:0] dcr_addr,
  input  logic [31:0]       dcr_wdata,
  output logic [31:0]       dcr_rdata,
  output logic [31:0]       ibase,
  output logic [31:0]       ictrl,
  output logic [31:0]       dbase,
  output logic [31:0]       dctrl
);
  import ocm_pkg::*;
  localparam int SEL_W = $clog2(NREGS);

  logic [31:0] reg_q [NREGS];
  logic [NREGS-1:0] sel;

  // even slots are bases, odd slots are controls
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    assign sel[g] = (dcr_addr == REG_BASE_ADDR + DCR_AW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)
        reg_q[g] <= '0;
      else if (dcr_wr && sel[g])
        reg_q[g] <= (g % 2 == 0) ? keep_base(dcr_wdata) : keep_ctrl(dcr_wdata);
    end
  end

  always_comb begin
    dcr_rdata = '0;
    for (int i = 0; i < NREGS; i++)
      if (dcr_rd && sel[i]) dcr_rdata = reg_q[i];
  end

  assign ibase = reg_q[0];
  assign ictrl = reg_q[1];
  assign dbase = reg_q[2];
  assign dctrl = reg_q[3];

  logic [SEL_W-1:0] unused_sel_w;
  assign unused_sel_w = '0;

  assert_base_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dcr_wr && dcr_addr == REG_BASE_ADDR) |=> (ibase == ($past(dcr_wdata) & 32'hFC00_0000)));
  assert_ctrl_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dcr_wr && dcr_addr == REG_BASE_ADDR + DCR_AW'(3)) |=> (dctrl == ($past(dcr_wdata) & 32'hC000_0000)));
  assert_other_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dcr_wr && sel == '0) |=> ($stable(ibase) && $stable(ictrl) && $stable(dbase) && $stable(dctrl)));
endmodule

// File: rtl/ocm_decode.sv
module ocm_decode #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ibase,
  input  logic [31:0]      ictrl,
  input  logic [31:0]      dbase,
  input  logic [31:0]      dctrl,
  input  logic [31:0]      bus_addr,
  output logic             i_hit,
  output logic             d_hit,
  output logic             any_hit,
  output logic [IDX_W-1:0] word_idx
);
  import ocm_pkg::*;
  assign i_hit    = win_hit(ibase, ictrl, bus_addr);
  assign d_hit    = win_hit(dbase, dctrl, bus_addr);
  // one storage, so overlapping windows merge into a single claim
  assign any_hit  = i_hit | d_hit;
  assign word_idx = bus_addr[IDX_W+1:2];

  assert_overlap_same_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (i_hit && d_hit) |-> (ibase[31:26] == dbase[31:26]));
  assert_hit_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (ictrl[31] || dctrl[31]));
endmodule

// File: rtl/ocm_ram.sv
module ocm_ram #(
  parameter int WORDS = 1024,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rdata <= mem[idx];
    else       rdata <= '0;
  end
endmodule

// File: rtl/ocm_mapper.sv
module ocm_mapper #(
  parameter int DCR_AW = 10,
  parameter int RAM_BYTES = 4096,
  parameter logic [DCR_AW-1:0] REG_BASE_ADDR = 10'h018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dcr_wr,
  input  logic              dcr_rd,
  input  logic [DCR_AW-1:0] dcr_addr,
  input  logic [31:0]       dcr_wdata,
  output logic [31:0]       dcr_rdata,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              bus_err
);
  localparam int WORDS = RAM_BYTES / 4;
  localparam int IDX_W = $clog2(WORDS);

  logic [31:0] ibase, ictrl, dbase, dctrl;
  logic i_hit, d_hit, any_hit;
  logic [IDX_W-1:0] word_idx;
  logic ram_wr, ram_rd;
  logic [31:0] ram_q;

  ocm_regs #(.DCR_AW(DCR_AW), .REG_BASE_ADDR(REG_BASE_ADDR), .NREGS(4)) u_regs (
    .clk(clk), .rst_n(rst_n), .dcr_wr(dcr_wr), .dcr_rd(dcr_rd), .dcr_addr(dcr_addr),
    .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata),
    .ibase(ibase), .ictrl(ictrl), .dbase(dbase), .dctrl(dctrl));

  ocm_decode #(.IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ibase(ibase), .ictrl(ictrl), .dbase(dbase), .dctrl(dctrl),
    .bus_addr(bus_addr), .i_hit(i_hit), .d_hit(d_hit), .any_hit(any_hit), .word_idx(word_idx));

  assign ram_wr = bus_req && bus_we && any_hit;
  assign ram_rd = bus_req && !bus_we && any_hit;

  ocm_ram #(.WORDS(WORDS)) u_ram (
    .clk(clk), .wr_en(ram_wr), .rd_en(ram_rd), .idx(word_idx),
    .wdata(bus_wdata), .rdata(ram_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      bus_ack <= bus_req && any_hit;
      bus_err <= bus_req && !any_hit;
    end
  end
  assign bus_rdata = ram_q;

  assert_ack_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_err));
  assert_req_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> (bus_ack || bus_err));
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !(bus_ack || bus_err));
  assert_miss_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(i_hit || d_hit)) |=> (bus_err && !bus_ack));
endmodule

// File: tb/ocm_mapper_tb.sv
module ocm_mapper_tb;
  logic clk = 0, rst_n = 0;
  logic dcr_wr = 0, dcr_rd = 0;
  logic [9:0] dcr_addr = '0;
  logic [31:0] dcr_wdata = '0, dcr_rdata;
  logic bus_req = 0, bus_we = 0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_ack, bus_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_reg [4];
  logic [31:0] m_mem [1024];
  bit          m_valid [1024];

  localparam logic [9:0] A_IBASE = 10'h018, A_ICTRL = 10'h019, A_DBASE = 10'h01A, A_DCTRL = 10'h01B;

  ocm_mapper u_dut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] mask_for(input int slot, input logic [31:0] v);
    return (slot % 2 == 0) ? {v[31:26], 26'd0} : {v[31:30], 30'd0};
  endfunction
  function automatic bit model_hit(input logic [31:0] a);
    bit hi = m_reg[1][31] && (m_reg[0][31:26] == a[31:26]);
    bit hd = m_reg[3][31] && (m_reg[2][31:26] == a[31:26]);
    return hi || hd;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dcr_write(input logic [9:0] a, input logic [31:0] v);
    @(negedge clk);
    dcr_wr = 1; dcr_addr = a; dcr_wdata = v;
    @(negedge clk);
    dcr_wr = 0;
    if (a >= A_IBASE && a <= A_DCTRL) m_reg[a - A_IBASE] = mask_for(int'(a - A_IBASE), v);
  endtask

  task automatic dcr_read(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    dcr_rd = 1; dcr_addr = a;
    #1 v = dcr_rdata;
    dcr_rd = 0;
  endtask

  task automatic bus_xfer(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output bit ack, output bit err, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    ack = bus_ack; err = bus_err; rd = bus_rdata;
    bus_req = 0; bus_we = 0;
  endtask

  // access with full model comparison
  task automatic bus_checked(input string req, input bit we, input logic [31:0] a,
                             input logic [31:0] wd);
    bit ack, err; logic [31:0] rd;
    bit h = model_hit(a);
    int idx = int'(a[11:2]);
    bus_xfer(we, a, wd, ack, err, rd);
    check(req, {30'd0, ack, err}, {30'd0, h, !h});
    if (h && !we && m_valid[idx]) check(req, rd, m_mem[idx]);
    if (h && we) begin m_mem[idx] = wd; m_valid[idx] = 1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit ack, err; logic [31:0] rd;
    void'($urandom(32'h0C0FFEE5));
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    for (int i = 0; i < 1024; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      dcr_read(A_IBASE + 10'(i), v);
      check("R1 reg zero", v, 32'h0);
    end
    bus_xfer(0, 32'h0000_0010, 0, ack, err, rd);
    check("R1 access errs", {30'd0, ack, err}, 32'h1);

    // R2 / R3 masking
    dcr_write(A_IBASE, 32'h4BCD_EF12);
    dcr_read(A_IBASE, v); check("R2 ibase mask", v, 32'h4800_0000);
    dcr_write(A_DBASE, 32'hFFFF_FFFF);
    dcr_read(A_DBASE, v); check("R2 dbase mask", v, 32'hFC00_0000);
    dcr_write(A_ICTRL, 32'h7FFF_FFFF);
    dcr_read(A_ICTRL, v); check("R3 ctrl mask, bit30 kept", v, 32'h4000_0000);
    // R3 bit30 alone does not enable
    bus_checked("R3 bit30 no enable", 0, 32'h4800_0000, 0);

    // R11 other addresses
    dcr_write(10'h01C, 32'hFFFF_FFFF);
    dcr_write(10'h017, 32'hFFFF_FFFF);
    dcr_read(10'h01C, v); check("R11 other read zero", v, 32'h0);
    dcr_read(A_IBASE, v); check("R11 ibase untouched", v, 32'h4800_0000);
    dcr_read(A_DCTRL, v); check("R11 dctrl untouched", v, 32'h0);

    // R9 enable then access next cycle
    @(negedge clk);
    dcr_wr = 1; dcr_addr = A_ICTRL; dcr_wdata = 32'h8000_0000;
    @(negedge clk);
    dcr_wr = 0; m_reg[1] = 32'h8000_0000;
    bus_req = 1; bus_we = 1; bus_addr = 32'h4800_0040; bus_wdata = 32'hA5A5_0001;
    @(negedge clk);
    check("R9 access right after enable acks", {31'd0, bus_ack}, 32'h1);
    bus_req = 0; bus_we = 0;
    m_mem[16] = 32'hA5A5_0001; m_valid[16] = 1;

    // R4 / R7 hit and offset wrap
    bus_checked("R4 read back", 0, 32'h4800_0040, 0);
    bus_checked("R7 bits 25:12 ignored", 0, 32'h4BFF_F040, 0);
    bus_checked("R4 other region misses", 0, 32'h4C00_0040, 0);

    // R5 miss write does not touch ram
    bus_checked("R5 miss write", 1, 32'h0000_0040, 32'hDEAD_BEEF);
    bus_checked("R5 ram intact", 0, 32'h4800_0040, 0);

    // R6 alias: data window elsewhere
    dcr_write(A_DBASE, 32'h0800_0000);
    dcr_write(A_DCTRL, 32'h8000_0000);
    bus_checked("R6 write via data", 1, 32'h0800_0FFC, 32'h1234_5678);
    bus_checked("R6 read via instr", 0, 32'h4800_0FFC, 0);
    bus_checked("R6 read via data", 0, 32'h0800_0040, 0);

    // R8 both windows same base
    dcr_write(A_DBASE, 32'h4800_0000);
    bus_xfer(1, 32'h4800_0100, 32'hCAFE_F00D, ack, err, rd);
    check("R8 single ack on write", {30'd0, ack, err}, 32'h2);
    m_mem[64] = 32'hCAFE_F00D; m_valid[64] = 1;
    bus_xfer(0, 32'h4800_0100, 0, ack, err, rd);
    check("R8 single ack on read", {30'd0, ack, err}, 32'h2);
    check("R8 shared data", rd, 32'hCAFE_F00D);

    // R10 idle produces no response
    @(negedge clk);
    check("R10 idle no response", {30'd0, bus_ack, bus_err}, 32'h0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int k = int'($urandom_range(0, 9));
      logic [31:0] bases [4];
      bases[0] = 32'h0000_0000; bases[1] = 32'h0400_0000;
      bases[2] = 32'h4800_0000; bases[3] = 32'hFC00_0000;
      if (k == 0) begin
        int s = int'($urandom_range(0, 3));
        logic [31:0] val = (s % 2 == 0) ? (bases[$urandom_range(0, 3)] | ($urandom() & 32'h03FF_FFFF))
                                        : $urandom();
        dcr_write(A_IBASE + 10'(s), val);
        dcr_read(A_IBASE + 10'(s), v);
        check(s % 2 == 0 ? "R2 random base" : "R3 random ctrl", v, m_reg[s]);
      end else begin
        logic [31:0] a = bases[$urandom_range(0, 3)] | ($urandom() & 32'h03FF_FFFC);
        a[11:4] = 8'($urandom_range(0, 3));
        bus_checked("R4 random access", 1'($urandom_range(0, 1)), a, $urandom());
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule